// File: doc/BRIEF.md
# Pipeline Hazard Detection Unit

This block is the hazard logic for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) in which branches are resolved by an equality comparator in the decode stage. It takes register numbers and control flags from the stage fields and produces three groups of outputs. The first group is the bypass selects for the two execute-stage ALU operands. The second is the bypass selects for the two decode-stage comparator operands. The third is the stall and flush controls that hold fetch and decode and insert a bubble into execute.

Two conditions raise a stall. A load in execute whose target is read by the instruction in decode raises one. A decode-stage branch whose operands are still being produced in execute, or are being loaded in memory, raises the other. Both conditions drive a single stall/flush. A taken branch clears the fetch/decode pipeline register, except while a stall holds decode. Every output is a pure function of the present inputs. The pipeline registers themselves sit outside this block.

Top module: `hz_unit`

## Requirements
- R1: Operand A of execute selects code 2'b10 (memory bypass) when rs_e is non-zero, equals dst_m and wr_en_m is set; otherwise code 2'b01 (writeback bypass) when rs_e is non-zero, equals dst_w and wr_en_w is set; otherwise code 2'b00 (register file). Code 2'b11 never appears.
- R2: Operand B of execute follows the R1 rule with rt_e in place of rs_e.
- R3: Register number 0 is never bypassed, on any of the four operand selects, whatever the destinations and write enables.
- R4: Load-use stall: when ld_e is set and rt_e equals rs_d or rt_d, stall_f, stall_d and flush_e are 1.
- R5: cmp_fwd_a_d is 1 exactly when rs_d is non-zero, equals dst_m and wr_en_m is set; cmp_fwd_b_d uses the same test with rt_d. A writeback-stage match does not set them.
- R6: Branch stall on execute: when br_d is set, wr_en_e is set and dst_e equals rs_d or rt_d, the stall outputs are 1.
- R7: Branch stall on memory: when br_d is set, ld_m is set and dst_m equals rs_d or rt_d, the stall outputs are 1. A non-load write in memory does not stall a branch.
- R8: stall_f, stall_d and flush_e are always equal, and are 1 exactly when the R4 condition or one of the branch conditions of R6 and R7 holds.
- R9: flush_d equals br_taken_d while no stall is raised, and is 0 while a stall is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs_d | input | 5 | First source register in decode |
| rt_d | input | 5 | Second source register in decode |
| rs_e | input | 5 | First source register in execute |
| rt_e | input | 5 | Second source register in execute |
| dst_e | input | 5 | Destination register in execute |
| dst_m | input | 5 | Destination register in memory |
| dst_w | input | 5 | Destination register in writeback |
| wr_en_e | input | 1 | Execute instruction writes a register |
| wr_en_m | input | 1 | Memory instruction writes a register |
| wr_en_w | input | 1 | Writeback instruction writes a register |
| ld_e | input | 1 | Execute instruction is a load |
| ld_m | input | 1 | Memory instruction is a load |
| br_d | input | 1 | Decode instruction is a branch |
| br_taken_d | input | 1 | Decode comparator resolves the branch as taken |
| fwd_a_e | output | 2 | Execute operand A select |
| fwd_b_e | output | 2 | Execute operand B select |
| cmp_fwd_a_d | output | 1 | Comparator operand A takes the memory-stage result |
| cmp_fwd_b_d | output | 1 | Comparator operand B takes the memory-stage result |
| stall_f | output | 1 | Hold fetch |
| stall_d | output | 1 | Hold decode |
| flush_e | output | 1 | Bubble into execute |
| flush_d | output | 1 | Clear fetch/decode register on a taken branch |

## Verification
The bench targets the case where memory and writeback both match the same source. A design with the priority reversed would feed the older writeback value to the ALU. It also targets register 0 with live write enables, where a faulty design would bypass a constant-zero read. For branches, it separates a memory-stage load, which must stall, from a memory-stage ALU write, which must be bypassed and not stall; a design that confused the two would either lose cycles or compare a stale value. It also drives a taken branch during a stall, where a missing suppression would discard the branch instruction still held in decode.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int REG_AW = 5;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } exe_sel_t;
endpackage

// File: rtl/hz_exe_bypass.sv
module hz_exe_bypass
  import hz_pkg::*;
#(
  parameter int AW = REG_AW
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst_m,
  input  logic          wr_en_m,
  input  logic [AW-1:0] dst_w,
  input  logic          wr_en_w,
  output logic [1:0]    sel
);
  logic live;
  logic hit_m;
  logic hit_w;

  assign live  = (src != '0);
  assign hit_m = live && wr_en_m && (src == dst_m);
  assign hit_w = live && wr_en_w && (src == dst_w);

  always_comb begin
    if (hit_m)      sel = SEL_MEM;
    else if (hit_w) sel = SEL_WB;
    else            sel = SEL_RF;
  end

  always_comb begin
    AST_SEL_LEGAL: assert (sel != 2'b11) else $error("illegal select"); // R1
    AST_ZERO_NO_BYPASS: assert (src != '0 || sel == SEL_RF) else $error("r0 bypassed"); // R3
  end
endmodule

// File: rtl/hz_cmp_bypass.sv
module hz_cmp_bypass
  import hz_pkg::*;
#(
  parameter int AW = REG_AW
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst_m,
  input  logic          wr_en_m,
  output logic          use_m
);
  assign use_m = (src != '0) && wr_en_m && (src == dst_m);

  always_comb begin
    AST_CMP_NEEDS_WRITE: assert (!use_m || wr_en_m) else $error("bypass without write"); // R5
  end
endmodule

// File: rtl/hz_stall_ctl.sv
module hz_stall_ctl
  import hz_pkg::*;
#(
  parameter int AW = REG_AW
) (
  input  logic [AW-1:0] rs_d,
  input  logic [AW-1:0] rt_d,
  input  logic [AW-1:0] rt_e,
  input  logic [AW-1:0] dst_e,
  input  logic [AW-1:0] dst_m,
  input  logic          wr_en_e,
  input  logic          ld_e,
  input  logic          ld_m,
  input  logic          br_d,
  output logic          stall
);
  logic load_use;
  logic br_on_e;
  logic br_on_m;

  assign load_use = ld_e && ((rt_e == rs_d) || (rt_e == rt_d));
  assign br_on_e  = br_d && wr_en_e && ((dst_e == rs_d) || (dst_e == rt_d));
  assign br_on_m  = br_d && ld_m && ((dst_m == rs_d) || (dst_m == rt_d));
  assign stall    = load_use || br_on_e || br_on_m;
endmodule

// File: rtl/hz_unit.sv
module hz_unit
  import hz_pkg::*;
#(
  parameter int AW = REG_AW
) (
  input  logic [AW-1:0] rs_d,
  input  logic [AW-1:0] rt_d,
  input  logic [AW-1:0] rs_e,
  input  logic [AW-1:0] rt_e,
  input  logic [AW-1:0] dst_e,
  input  logic [AW-1:0] dst_m,
  input  logic [AW-1:0] dst_w,
  input  logic          wr_en_e,
  input  logic          wr_en_m,
  input  logic          wr_en_w,
  input  logic          ld_e,
  input  logic          ld_m,
  input  logic          br_d,
  input  logic          br_taken_d,
  output logic [1:0]    fwd_a_e,
  output logic [1:0]    fwd_b_e,
  output logic          cmp_fwd_a_d,
  output logic          cmp_fwd_b_d,
  output logic          stall_f,
  output logic          stall_d,
  output logic          flush_e,
  output logic          flush_d
);
  localparam int NOPS = 2;

  logic [AW-1:0] src_e [NOPS];
  logic [AW-1:0] src_d [NOPS];
  logic [1:0]    sel_e [NOPS];
  logic          sel_d [NOPS];
  logic          stall;

  assign src_e[0] = rs_e;
  assign src_e[1] = rt_e;
  assign src_d[0] = rs_d;
  assign src_d[1] = rt_d;

  for (genvar i = 0; i < NOPS; i++) begin : g_op
    hz_exe_bypass #(.AW(AW)) u_exe (
      .src    (src_e[i]),
      .dst_m  (dst_m),
      .wr_en_m(wr_en_m),
      .dst_w  (dst_w),
      .wr_en_w(wr_en_w),
      .sel    (sel_e[i])
    );
    hz_cmp_bypass #(.AW(AW)) u_cmp (
      .src    (src_d[i]),
      .dst_m  (dst_m),
      .wr_en_m(wr_en_m),
      .use_m  (sel_d[i])
    );
  end

  hz_stall_ctl #(.AW(AW)) u_stall (
    .rs_d   (rs_d),
    .rt_d   (rt_d),
    .rt_e   (rt_e),
    .dst_e  (dst_e),
    .dst_m  (dst_m),
    .wr_en_e(wr_en_e),
    .ld_e   (ld_e),
    .ld_m   (ld_m),
    .br_d   (br_d),
    .stall  (stall)
  );

  assign fwd_a_e     = sel_e[0];
  assign fwd_b_e     = sel_e[1];
  assign cmp_fwd_a_d = sel_d[0];
  assign cmp_fwd_b_d = sel_d[1];
  assign stall_f     = stall;
  assign stall_d     = stall;
  assign flush_e     = stall;
  assign flush_d     = br_taken_d && !stall;

  always_comb begin
    AST_FLUSH_NOT_IN_STALL: assert (!(flush_d && stall_d)) else $error("flush during stall"); // R9
    AST_LOAD_USE_HOLDS: assert (!(ld_e && (rt_e == rs_d || rt_e == rt_d)) || stall_d) else $error("load-use missed"); // R4
    AST_BR_LOAD_M_HOLDS: assert (!(br_d && ld_m && (dst_m == rs_d || dst_m == rt_d)) || stall_f) else $error("branch on load missed"); // R7
  end
endmodule

// File: tb/hz_unit_bench.sv
module hz_unit_bench;
  localparam int AW = 5;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [AW-1:0] rs_d, rt_d, rs_e, rt_e, dst_e, dst_m, dst_w;
  logic wr_en_e, wr_en_m, wr_en_w, ld_e, ld_m, br_d, br_taken_d;
  logic [1:0] fwd_a_e, fwd_b_e;
  logic cmp_fwd_a_d, cmp_fwd_b_d, stall_f, stall_d, flush_e, flush_d;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  hz_unit #(.AW(AW)) u_hz_unit (.*);

  function automatic logic [1:0] m_exe(input logic [AW-1:0] s);
    if (s != 0 && wr_en_m && s == dst_m) return 2'b10;
    if (s != 0 && wr_en_w && s == dst_w) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic m_cmp(input logic [AW-1:0] s);
    return (s != 0) && wr_en_m && (s == dst_m);
  endfunction

  function automatic logic m_stall();
    logic a, b, c;
    a = ld_e && (rt_e == rs_d || rt_e == rt_d);
    b = br_d && wr_en_e && (dst_e == rs_d || dst_e == rt_d);
    c = br_d && ld_m && (dst_m == rs_d || dst_m == rt_d);
    return a || b || c;
  endfunction

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic check_all(input string ctx);
    logic s;
    s = m_stall();
    chk({"R1 fwd_a_e ", ctx}, fwd_a_e, m_exe(rs_e));
    chk({"R2 fwd_b_e ", ctx}, fwd_b_e, m_exe(rt_e));
    chk({"R5 cmp_fwd_a_d ", ctx}, {1'b0, cmp_fwd_a_d}, {1'b0, m_cmp(rs_d)});
    chk({"R5 cmp_fwd_b_d ", ctx}, {1'b0, cmp_fwd_b_d}, {1'b0, m_cmp(rt_d)});
    chk({"R8 stall_f ", ctx}, {1'b0, stall_f}, {1'b0, s});
    chk({"R8 stall_d ", ctx}, {1'b0, stall_d}, {1'b0, s});
    chk({"R8 flush_e ", ctx}, {1'b0, flush_e}, {1'b0, s});
    chk({"R9 flush_d ", ctx}, {1'b0, flush_d}, {1'b0, br_taken_d && !s});
  endtask

  task automatic idle();
    {rs_d, rt_d, rs_e, rt_e, dst_e, dst_m, dst_w} = '0;
    {wr_en_e, wr_en_m, wr_en_w, ld_e, ld_m, br_d, br_taken_d} = '0;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(WATCHDOG * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    repeat (3) @(posedge clk);
    rst = 1'b0;
    settle();
    chk("R8 idle stall", {1'b0, stall_d}, 2'b00);
    chk("R1 idle fwd_a_e", fwd_a_e, 2'b00);
    check_all("idle");

    // R1 priority: memory wins over writeback on same register
    idle(); rs_e = 5'd7; rt_e = 5'd9; dst_m = 5'd7; dst_w = 5'd7; wr_en_m = 1; wr_en_w = 1;
    settle();
    chk("R1 mem over wb", fwd_a_e, 2'b10);
    chk("R2 no match", fwd_b_e, 2'b00);
    // R2 writeback path
    dst_w = 5'd9;
    settle();
    chk("R2 wb path", fwd_b_e, 2'b01);
    // R1 memory match without write enable falls to writeback
    wr_en_m = 0; dst_w = 5'd7;
    settle();
    chk("R1 wb when mem idle", fwd_a_e, 2'b01);

    // R3 register zero
    idle(); dst_m = 0; dst_w = 0; wr_en_m = 1; wr_en_w = 1;
    settle();
    chk("R3 r0 fwd_a_e", fwd_a_e, 2'b00);
    chk("R3 r0 fwd_b_e", fwd_b_e, 2'b00);
    chk("R3 r0 cmp_fwd_a_d", {1'b0, cmp_fwd_a_d}, 2'b00);

    // R4 load-use
    idle(); ld_e = 1; rt_e = 5'd4; rt_d = 5'd4; rs_d = 5'd2;
    settle();
    chk("R4 load-use rt", {1'b0, stall_f}, 2'b01);
    rt_d = 5'd3; rs_d = 5'd4;
    settle();
    chk("R4 load-use rs", {1'b0, flush_e}, 2'b01);
    ld_e = 0;
    settle();
    chk("R4 no load no stall", {1'b0, stall_d}, 2'b00);

    // R5 decode compare bypass only from memory
    idle(); rs_d = 5'd6; rt_d = 5'd8; dst_m = 5'd6; wr_en_m = 1; dst_w = 5'd8; wr_en_w = 1;
    settle();
    chk("R5 cmp a mem", {1'b0, cmp_fwd_a_d}, 2'b01);
    chk("R5 cmp b not from wb", {1'b0, cmp_fwd_b_d}, 2'b00);

    // R6 branch on execute write
    idle(); br_d = 1; rs_d = 5'd11; dst_e = 5'd11; wr_en_e = 1;
    settle();
    chk("R6 branch on exe", {1'b0, stall_d}, 2'b01);
    // R7 branch on memory load vs memory ALU write
    idle(); br_d = 1; rt_d = 5'd12; dst_m = 5'd12; wr_en_m = 1; ld_m = 1;
    settle();
    chk("R7 branch on mem load", {1'b0, stall_f}, 2'b01);
    ld_m = 0;
    settle();
    chk("R7 mem alu no stall", {1'b0, stall_f}, 2'b00);
    chk("R7 mem alu bypassed", {1'b0, cmp_fwd_b_d}, 2'b01);

    // R9 taken branch flush, suppressed by stall
    br_taken_d = 1;
    settle();
    chk("R9 taken flush", {1'b0, flush_d}, 2'b01);
    ld_m = 1;
    settle();
    chk("R9 flush held in stall", {1'b0, flush_d}, 2'b00);

    // randomized mix with narrow register range to force collisions
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rs_d = AW'($urandom_range(0, 3)); rt_d = AW'($urandom_range(0, 3));
      rs_e = AW'($urandom_range(0, 3)); rt_e = AW'($urandom_range(0, 3));
      dst_e = AW'($urandom_range(0, 3)); dst_m = AW'($urandom_range(0, 3));
      dst_w = AW'($urandom_range(0, 3));
      {wr_en_e, wr_en_m, wr_en_w, ld_e, ld_m, br_d, br_taken_d} = 7'($urandom);
      #1;
      check_all("random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule